// File: doc/BRIEF.md
# Bit-Test Skip and Clear Execute Unit

This unit sits in the execute stage of a small 8-bit accumulator processor. It carries out four operations: test one bit of a register-file location and skip if that bit is 1, the same test with a skip if the bit is 0, zero a register-file location, and zero the working register. The decoded opcode, file address and bit index arrive with the read data already fetched from the register file for that address. The unit drives a register-file write port, a working-register write port, and a zero flag.

A taken skip does not redirect the program counter. The unit instead raises a squash state that turns the next accepted instruction into a no-op, so a taken skip costs one extra instruction slot. The instruction stream is a valid/ready interface. `in_ready` is always high, so the unit never applies back-pressure, and a slot counts only when `in_valid` is high. Idle cycles (`in_valid` low) neither consume nor cancel a pending squash.

Top module: `bts_unit`

## Requirements
- R1: Opcode 1 (skip-if-one): if bit `in_bit` of `rd_data` is 1, the next accepted instruction is squashed; if it is 0, the next instruction executes.
- R2: Opcode 2 (skip-if-zero): if the selected bit is 0, the next accepted instruction is squashed; if it is 1, the next instruction executes.
- R3: Every file address 0..127 and every bit index 0..7 selects the matching location and bit, including the extremes 0 and 127 and bit 7.
- R4: The squash covers exactly one accepted instruction. That instruction produces no register-file write, no working-register write and no zero-flag change, and `squash_o` falls after it is accepted.
- R5: A skip instruction that is itself squashed never raises a further squash, whatever its selected bit.
- R6: Neither bit-test opcode changes the zero flag.
- R7: Opcode 3 (zero file) drives `rf_we` high in its cycle with `rf_waddr` = `in_addr` and `rf_wdata` = 00h, and the zero flag reads 1 after the edge.
- R8: Opcode 4 (zero working register) drives `w_we` high with `w_wdata` = 00h, and the zero flag reads 1 after the edge.
- R9: While and after reset, `squash_o` and `z_flag` are 0. Reset cancels a pending squash.
- R10: Cycles with `in_valid` low leave `squash_o` and `z_flag` unchanged. Opcode 0 (other) writes nothing and changes no flag, but it still consumes a squash slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_ready | output | 1 | Always 1; the unit accepts every cycle |
| in_op | input | 3 | Opcode: 0 other, 1 skip-if-one, 2 skip-if-zero, 3 zero file, 4 zero working register |
| in_addr | input | 7 | Register-file address operand |
| in_bit | input | 3 | Bit index operand |
| rd_data | input | 8 | Register-file contents at `in_addr` |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 7 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| w_we | output | 1 | Working-register write enable |
| w_wdata | output | 8 | Working-register write data |
| z_flag | output | 1 | Zero flag |
| squash_o | output | 1 | The next accepted instruction will be turned into a no-op |

## Verification
The assertions assume that `rd_data` holds the register-file contents at `in_addr` in the same cycle, and that `in_op` carries only the five listed codes while `in_valid` is high. The bench meets both assumptions. Its register-file model is read combinationally at the driven address. All stimulus is applied at the falling edge from a table whose opcodes are drawn only from that set. Operands are held stable until after the rising edge, so the write ports are sampled while the inputs are settled.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [2:0] {
    OP_OTHER     = 3'd0,
    OP_SKIP_ONE  = 3'd1,
    OP_SKIP_ZERO = 3'd2,
    OP_ZERO_FILE = 3'd3,
    OP_ZERO_ACC  = 3'd4
  } op_e;
endpackage

// File: rtl/bts_bit_sel.sv
module bts_bit_sel #(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [BIT_W-1:0]  idx,
  output logic              bit_val
);
  logic [DATA_W-1:0] hit;

  // One-hot AND-OR selection of the indexed bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign hit[g] = data[g] && (idx == BIT_W'(g));
  end

  assign bit_val = |hit;
endmodule

// File: rtl/bts_skip_ctl.sv
module bts_skip_ctl
  import bts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  op_e  op,
  input  logic bit_val,
  output logic squash_q,
  output logic live
);
  logic taken;
  logic squash_d;

  // An instruction is live only when it is accepted and not squashed
  assign live  = accept && !squash_q;
  assign taken = live && ((op == OP_SKIP_ONE  &&  bit_val) ||
                          (op == OP_SKIP_ZERO && !bit_val));
  assign squash_d = accept ? taken : squash_q;

  always_ff @(posedge clk) begin
    if (!rst_n) squash_q <= 1'b0;
    else        squash_q <= squash_d;
  end

  // R5 and R4: a squashed slot never re-arms the squash
  a_r5_no_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && squash_q) |=> !squash_q);
  // R10: idle cycles hold the pending squash
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(squash_q));
endmodule

// File: rtl/bts_clear_path.sv
module bts_clear_path
  import bts_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              w_we,
  output logic [DATA_W-1:0] w_wdata,
  output logic              z_q
);
  assign rf_we    = live && (op == OP_ZERO_FILE);
  assign rf_waddr = addr;
  assign rf_wdata = '0;
  assign w_we     = live && (op == OP_ZERO_ACC);
  assign w_wdata  = '0;

  always_ff @(posedge clk) begin
    if (!rst_n)            z_q <= 1'b0;
    else if (rf_we || w_we) z_q <= 1'b1;
  end

  // R6: bit tests leave the zero flag alone
  a_r6_test_keeps_z: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SKIP_ONE || op == OP_SKIP_ZERO) |=> $stable(z_q));
  // R7 / R8: an executed clear leaves the zero flag set
  a_r7_clear_sets_z: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || w_we) |=> z_q);
endmodule

// File: rtl/bts_unit.sv
module bts_unit
  import bts_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BIT_W-1:0]  in_bit,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              w_we,
  output logic [DATA_W-1:0] w_wdata,
  output logic              z_flag,
  output logic              squash_o
);
  op_e  op;
  logic accept;
  logic bit_val;
  logic live;

  assign op       = op_e'(in_op);
  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;

  bts_bit_sel #(.DATA_W(DATA_W)) u_sel (
    .data(rd_data), .idx(in_bit), .bit_val(bit_val)
  );

  bts_skip_ctl u_skip (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op(op),
    .bit_val(bit_val), .squash_q(squash_o), .live(live)
  );

  bts_clear_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_clr (
    .clk(clk), .rst_n(rst_n), .live(live), .op(op), .addr(in_addr),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .w_we(w_we), .w_wdata(w_wdata), .z_q(z_flag)
  );

  // R4: a squashed slot writes nothing
  a_r4_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && squash_o) |-> (!rf_we && !w_we));
  // R4: a squashed slot leaves the zero flag unchanged
  a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && squash_o) |=> $stable(z_flag));
endmodule

// File: tb/sim_bts_unit.sv
module sim_bts_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = 3'd0;
  logic [6:0] in_addr = 7'd0;
  logic [2:0] in_bit = 3'd0;
  logic [7:0] rd_data;
  logic       rf_we, w_we, z_flag, squash_o;
  logic [6:0] rf_waddr;
  logic [7:0] rf_wdata, w_wdata;
  logic [7:0] rf [128];
  logic [7:0] wreg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bts_unit u0 (.*);

  assign rd_data = rf[in_addr];
  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (w_we)  wreg <= w_wdata;
  end

  // Table entries: {op, addr, bit, exp_write, exp_squash_after, exp_z_after}
  // The register file is preloaded with rf[a] = a
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    {3'd1, 7'd5,   3'd0, 1'b0, 1'b1, 1'b0}, // R1 taken
    {3'd0, 7'd0,   3'd0, 1'b0, 1'b0, 1'b0}, // R4 consumed
    {3'd1, 7'd5,   3'd1, 1'b0, 1'b0, 1'b0}, // R1 not taken
    {3'd2, 7'd6,   3'd0, 1'b0, 1'b1, 1'b0}, // R2 taken
    {3'd3, 7'd20,  3'd0, 1'b0, 1'b0, 1'b0}, // R4 squashed clear
    {3'd2, 7'd6,   3'd2, 1'b0, 1'b0, 1'b0}, // R2 not taken
    {3'd1, 7'd127, 3'd7, 1'b0, 1'b0, 1'b0}, // R3 bit 7
    {3'd1, 7'd127, 3'd6, 1'b0, 1'b1, 1'b0}, // R3 addr 127
    {3'd1, 7'd5,   3'd0, 1'b0, 1'b0, 1'b0}, // R5 squashed skip
    {3'd4, 7'd0,   3'd0, 1'b1, 1'b0, 1'b1}, // R8
    {3'd2, 7'd0,   3'd3, 1'b0, 1'b1, 1'b1}, // R6 / R3 addr 0
    {3'd4, 7'd0,   3'd0, 1'b0, 1'b0, 1'b1}, // R4 squashed clear-W
    {3'd3, 7'd20,  3'd0, 1'b1, 1'b0, 1'b1}, // R7
    {3'd2, 7'd20,  3'd4, 1'b0, 1'b1, 1'b1}, // R7 cleared bit reads 0
    {3'd0, 7'd1,   3'd0, 1'b0, 1'b0, 1'b1}  // R10 other op
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [6:0] a, input logic [2:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = a; in_bit = b;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) rf[i] = 8'(i);
    wreg = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R9 squash in reset", {7'd0, squash_o}, 8'd0);
    chk("R9 z in reset", {7'd0, z_flag}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 squash after reset", {7'd0, squash_o}, 8'd0);
    chk("R9 z after reset", {7'd0, z_flag}, 8'd0);
    chk("R10 ready", {7'd0, in_ready}, 8'd1);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      op = VEC[v][15:13];
      issue(op, VEC[v][12:6], VEC[v][5:3]);
      #2;
      chk($sformatf("R4/R7 rf_we v%0d", v), {7'd0, rf_we}, {7'd0, VEC[v][2] && op == 3'd3});
      chk($sformatf("R4/R8 w_we v%0d", v), {7'd0, w_we}, {7'd0, VEC[v][2] && op == 3'd4});
      if (op == 3'd3 && VEC[v][2]) begin
        chk("R7 waddr", {1'b0, rf_waddr}, {1'b0, VEC[v][12:6]});
        chk("R7 wdata", rf_wdata, 8'h00);
      end
      @(posedge clk); #1;
      chk($sformatf("R1/R2/R5 squash v%0d", v), {7'd0, squash_o}, {7'd0, VEC[v][1]});
      chk($sformatf("R6/R7/R8 z v%0d", v), {7'd0, z_flag}, {7'd0, VEC[v][0]});
    end
    @(negedge clk); in_valid = 1'b0;
    chk("R7 rf[20] cleared", rf[20], 8'h00);
    chk("R8 working reg cleared", wreg, 8'h00);
    chk("R5 rf[5] untouched", rf[5], 8'd5);

    // Directed: idle cycles keep a pending squash (R10)
    issue(3'd1, 7'd1, 3'd0);
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 squash held over idle", {7'd0, squash_o}, 8'd1);
    issue(3'd3, 7'd9, 3'd0); #2;
    chk("R4 squashed after idle", {7'd0, rf_we}, 8'd0);
    @(negedge clk); in_valid = 1'b0;
    chk("R4 squash released", {7'd0, squash_o}, 8'd0);
    chk("R4 rf[9] kept", rf[9], 8'd9);

    // Directed: reset cancels a pending squash and the flag (R9), then R7 from z=0
    issue(3'd2, 7'd2, 3'd0);
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 reset clears squash", {7'd0, squash_o}, 8'd0);
    chk("R9 reset clears z", {7'd0, z_flag}, 8'd0);
    issue(3'd3, 7'd9, 3'd0); #2;
    chk("R7 write after reset", {7'd0, rf_we}, 8'd1);
    @(negedge clk); in_valid = 1'b0;
    chk("R7 z set", {7'd0, z_flag}, 8'd1);
    chk("R7 rf[9] zero", rf[9], 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule